// File: doc/BRIEF.md
# Port Link-Down Traffic Disposition

This block sits beside the routing logic of a multi-port packet switch and decides what happens to transaction-layer packets when a port's data-link layer goes down. It watches a per-port link-up status and a per-port role: one upstream port faces the host, and the downstream ports face devices. When a link drops, it pulses flush strobes that empty that port's ingress queue and replay queue. A drop on an upstream port also raises a partition hot-reset request. When a link comes up, a credit re-advertise strobe goes out.

The routing path offers each packet as a descriptor. The descriptor carries the source port, whether the packet is a request, its destination bus number, and whether it targets a port's own function. The block answers one cycle later with a disposition. A packet bound for the bus of a downstream port whose link is down is answered as Unsupported Request if it is a request, and is dropped silently otherwise. All other packets are forwarded, and so is any packet aimed at a port's own function.

A downstream link drop also sets a sticky surprise-down status bit, which software clears by writing one. The bit stays clear when the drop was deliberate. A drop counts as deliberate when, since the link last came up, the partition was disabled, the port was disabled, an operating-mode change forced a full retrain, software forced a full retrain, or the clocking mode was changed.

Top module: `lnk_down_disposition`

## Requirements
- R1: A drop of `link_up[i]` (1 to 0) on a port whose `port_dn_role[i]` is 0 (upstream) pulses `hot_reset_req[i]` for exactly one cycle, one clock after the drop. A drop on a downstream-role port never raises it.
- R2: A drop of `link_up[i]` on a port of either role pulses both `ifb_flush[i]` and `replay_flush[i]` for exactly one cycle, one clock after the drop.
- R3: Port j matches a descriptor when `port_dn_role[j]` is 1, `port_bus[j*BUSW +: BUSW]` equals `tlp_dest_bus`, and j differs from `tlp_src`. If the matching port's link is down, `tlp_is_req` is 1 and `tlp_to_func` is 0, the disposition is Unsupported Request, `disp_code` = 2'b10.
- R4: Under the same match, a descriptor with `tlp_is_req` 0 gets the disposition drop, `disp_code` = 2'b01.
- R5: A descriptor with `tlp_to_func` 1 always gets the disposition forward, `disp_code` = 2'b00, even when the matching link is down.
- R6: A descriptor with no matching port, or whose matching port's link is up, gets the disposition forward (2'b00).
- R7: A rise of `link_up[i]` pulses `credit_adv[i]` for one cycle, one clock later. This includes the first cycle after reset in which the link is seen up.
- R8: A drop on a downstream-role port sets `sd_status[i]` one clock later unless a suppression qualifier applies. A drop on an upstream-role port never sets it.
- R9: A pulse on any of `sup_part_dis`, `sup_port_dis`, `sup_mode_rtr`, `sup_force_rtr` or `sup_clk_chg` for port i suppresses the surprise-down bit for a later drop, and for a drop in the same cycle. The qualifier stays in force until `link_up[i]` rises again.
- R10: `sd_status[i]` stays set until a cycle with `sd_clear[i]` high, which clears it. A new setting event in that same cycle wins over the clear.
- R11: A descriptor is accepted when `tlp_valid` and `tlp_ready` are both high. `disp_valid` and `disp_code` appear on the next clock. They are held unchanged while `disp_ready` is low, and `tlp_ready` equals `!disp_valid || disp_ready`. After reset, `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up | input | NPORTS | Data-link layer up, per port |
| port_dn_role | input | NPORTS | 1 = downstream role, 0 = upstream role |
| port_bus | input | NPORTS*BUSW | Bus number behind each downstream port |
| sup_part_dis | input | NPORTS | Partition placed in disabled state |
| sup_port_dis | input | NPORTS | Port placed in disabled mode |
| sup_mode_rtr | input | NPORTS | Full retrain caused by operating-mode change |
| sup_force_rtr | input | NPORTS | Full retrain forced by software |
| sup_clk_chg | input | NPORTS | Port clocking mode changed |
| sd_clear | input | NPORTS | Write-one-to-clear strobe for surprise-down status |
| tlp_valid | input | 1 | Descriptor valid |
| tlp_ready | output | 1 | Descriptor accepted when high with valid |
| tlp_src | input | PIDW | Port the packet arrived on |
| tlp_is_req | input | 1 | Packet is a request |
| tlp_dest_bus | input | BUSW | Destination bus number |
| tlp_to_func | input | 1 | Packet targets a port's own function |
| disp_valid | output | 1 | Disposition valid |
| disp_ready | input | 1 | Consumer takes the disposition |
| disp_code | output | 2 | 00 forward, 01 drop, 10 Unsupported Request |
| ifb_flush | output | NPORTS | Ingress queue flush pulse |
| replay_flush | output | NPORTS | Replay queue flush pulse |
| hot_reset_req | output | NPORTS | Partition hot-reset request pulse |
| credit_adv | output | NPORTS | Credit re-advertise pulse |
| sd_status | output | NPORTS | Sticky surprise-down status |

## Verification
The disposition logic is exercised from the upstream port towards each downstream bus. It is tried with a request, a completion, and a packet aimed at the port's own function, each sent both before and after one downstream link drops. This is what separates Unsupported Request from drop from forward. A bus number that matches no port, and a bus behind a link that is still up, show that only the dead link is affected. Surprise-down is tested with each of the five qualifiers in turn, with a qualifier pulsed in the same cycle as the drop, and with a plain drop after the link has come back up. Together these show that qualifiers are latched, that they cover same-cycle actions, and that they clear on link up.

// File: rtl/lnk_down_pkg.sv
package lnk_down_pkg;

  typedef enum logic [1:0] {
    DISP_FWD  = 2'b00,
    DISP_DROP = 2'b01,
    DISP_UR   = 2'b10
  } disp_e;

  // Disposition for one descriptor given whether its target link is dead.
  function automatic disp_e disp_for(input logic is_req,
                                     input logic dead_hit,
                                     input logic to_func);
    if (to_func || !dead_hit) return DISP_FWD;
    if (is_req)               return DISP_UR;
    return DISP_DROP;
  endfunction

  // Surprise-down is reported only for an unexpected downstream drop.
  function automatic logic sd_should_set(input logic fall,
                                         input logic dn_role,
                                         input logic suppressed);
    return fall && dn_role && !suppressed;
  endfunction

endpackage

// File: rtl/lnk_route_decider.sv
module lnk_route_decider #(
  parameter int NPORTS = 4,
  parameter int BUSW   = 8,
  localparam int PIDW  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [NPORTS*BUSW-1:0] port_bus,
  input  logic [NPORTS-1:0]      port_dn_role,
  input  logic [NPORTS-1:0]      link_up,
  input  logic [PIDW-1:0]        src,
  input  logic [BUSW-1:0]        dest_bus,
  output logic [NPORTS-1:0]      hit_vec,
  output logic                   dead_hit
);

  for (genvar j = 0; j < NPORTS; j++) begin : g_match
    assign hit_vec[j] = port_dn_role[j]
                     && (port_bus[j*BUSW +: BUSW] == dest_bus)
                     && (src != PIDW'(j));
  end

  assign dead_hit = |(hit_vec & ~link_up);

endmodule

// File: rtl/lnk_port_tracker.sv
module lnk_port_tracker
  import lnk_down_pkg::*;
#(
  parameter int NQUAL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             dn_role,
  input  logic [NQUAL-1:0] qual_start,
  input  logic             sd_clr,
  output logic             link_q,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic             ifb_flush,
  output logic             replay_flush,
  output logic             hot_reset,
  output logic             credit_adv,
  output logic             sd_status
);

  logic sup_q;
  logic sup_now;
  logic any_start;
  logic sd_set;

  assign fall_evt  = link_q & ~link_up;
  assign rise_evt  = ~link_q & link_up;
  assign any_start = |qual_start;
  assign sup_now   = sup_q | any_start;
  assign sd_set    = sd_should_set(fall_evt, dn_role, sup_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q       <= 1'b0;
      ifb_flush    <= 1'b0;
      replay_flush <= 1'b0;
      hot_reset    <= 1'b0;
      credit_adv   <= 1'b0;
      sup_q        <= 1'b0;
      sd_status    <= 1'b0;
    end else begin
      link_q       <= link_up;
      ifb_flush    <= fall_evt;
      replay_flush <= fall_evt;
      hot_reset    <= fall_evt & ~dn_role;
      credit_adv   <= rise_evt;
      if (any_start)     sup_q <= 1'b1;
      else if (rise_evt) sup_q <= 1'b0;
      if (sd_set)        sd_status <= 1'b1;
      else if (sd_clr)   sd_status <= 1'b0;
    end
  end

endmodule

// File: rtl/lnk_down_disposition.sv
module lnk_down_disposition
  import lnk_down_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int BUSW   = 8,
  localparam int PIDW  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS-1:0]      link_up,
  input  logic [NPORTS-1:0]      port_dn_role,
  input  logic [NPORTS*BUSW-1:0] port_bus,
  input  logic [NPORTS-1:0]      sup_part_dis,
  input  logic [NPORTS-1:0]      sup_port_dis,
  input  logic [NPORTS-1:0]      sup_mode_rtr,
  input  logic [NPORTS-1:0]      sup_force_rtr,
  input  logic [NPORTS-1:0]      sup_clk_chg,
  input  logic [NPORTS-1:0]      sd_clear,
  input  logic                   tlp_valid,
  output logic                   tlp_ready,
  input  logic [PIDW-1:0]        tlp_src,
  input  logic                   tlp_is_req,
  input  logic [BUSW-1:0]        tlp_dest_bus,
  input  logic                   tlp_to_func,
  output logic                   disp_valid,
  input  logic                   disp_ready,
  output logic [1:0]             disp_code,
  output logic [NPORTS-1:0]      ifb_flush,
  output logic [NPORTS-1:0]      replay_flush,
  output logic [NPORTS-1:0]      hot_reset_req,
  output logic [NPORTS-1:0]      credit_adv,
  output logic [NPORTS-1:0]      sd_status
);

  localparam int NQUAL = 5;

  logic [NPORTS-1:0] link_q;
  logic [NPORTS-1:0] fall_vec;
  logic [NPORTS-1:0] rise_vec;
  logic [NPORTS-1:0] hit_vec;
  logic              dead_hit;
  logic              accept;
  disp_e             next_disp;
  disp_e             disp_q;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    lnk_port_tracker #(.NQUAL(NQUAL)) u_trk (
      .clk          (clk),
      .rst_n        (rst_n),
      .link_up      (link_up[i]),
      .dn_role      (port_dn_role[i]),
      .qual_start   ({sup_part_dis[i], sup_port_dis[i], sup_mode_rtr[i],
                      sup_force_rtr[i], sup_clk_chg[i]}),
      .sd_clr       (sd_clear[i]),
      .link_q       (link_q[i]),
      .fall_evt     (fall_vec[i]),
      .rise_evt     (rise_vec[i]),
      .ifb_flush    (ifb_flush[i]),
      .replay_flush (replay_flush[i]),
      .hot_reset    (hot_reset_req[i]),
      .credit_adv   (credit_adv[i]),
      .sd_status    (sd_status[i])
    );
  end

  lnk_route_decider #(.NPORTS(NPORTS), .BUSW(BUSW)) u_route (
    .port_bus     (port_bus),
    .port_dn_role (port_dn_role),
    .link_up      (link_up),
    .src          (tlp_src),
    .dest_bus     (tlp_dest_bus),
    .hit_vec      (hit_vec),
    .dead_hit     (dead_hit)
  );

  assign tlp_ready = !disp_valid || disp_ready;
  assign accept    = tlp_valid && tlp_ready;
  assign next_disp = disp_for(tlp_is_req, dead_hit, tlp_to_func);
  assign disp_code = disp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_q     <= DISP_FWD;
    end else if (accept) begin
      disp_valid <= 1'b1;
      disp_q     <= next_disp;
    end else if (disp_ready) begin
      disp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lnk_down_disposition_chk.sv
module lnk_down_disposition_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] fall_vec,
  input logic [NPORTS-1:0] ifb_flush,
  input logic [NPORTS-1:0] replay_flush,
  input logic [NPORTS-1:0] hot_reset_req,
  input logic [NPORTS-1:0] credit_adv,
  input logic [NPORTS-1:0] sd_status,
  input logic [NPORTS-1:0] sd_clear,
  input logic              tlp_valid,
  input logic              tlp_ready,
  input logic              tlp_to_func,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [1:0]        disp_code
);

  // R2
  flush_follows_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ifb_flush == $past(fall_vec)) && (replay_flush == $past(fall_vec)));

  // R1
  hot_reset_with_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_reset_req & ~ifb_flush) == '0);

  // R7
  credit_not_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_adv & ifb_flush) == '0);

  // R8
  sd_rise_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sd_status & ~$past(sd_status) & ~ifb_flush) == '0));

  // R10
  sd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sd_status) & ~$past(sd_clear) & ~sd_status) == '0));

  // R11
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_code)));

  // R5
  own_func_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlp_valid && tlp_ready && tlp_to_func) |=> (disp_valid && disp_code == 2'b00));

endmodule

bind lnk_down_disposition lnk_down_disposition_chk #(.NPORTS(NPORTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fall_vec      (fall_vec),
  .ifb_flush     (ifb_flush),
  .replay_flush  (replay_flush),
  .hot_reset_req (hot_reset_req),
  .credit_adv    (credit_adv),
  .sd_status     (sd_status),
  .sd_clear      (sd_clear),
  .tlp_valid     (tlp_valid),
  .tlp_ready     (tlp_ready),
  .tlp_to_func   (tlp_to_func),
  .disp_valid    (disp_valid),
  .disp_ready    (disp_ready),
  .disp_code     (disp_code)
);

// File: tb/lnk_down_disposition_bench.sv
module lnk_down_disposition_bench;
  localparam int CLK_P  = 10;
  localparam int NPORTS = 4;
  localparam int BUSW   = 8;
  localparam int PIDW   = 2;
  localparam logic [1:0] FWD = 2'b00, DROP = 2'b01, UR = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPORTS-1:0] link_up = '0, port_dn_role = 4'b1110;
  logic [NPORTS*BUSW-1:0] port_bus = {8'h30, 8'h20, 8'h10, 8'h00};
  logic [NPORTS-1:0] sup_part_dis = '0, sup_port_dis = '0, sup_mode_rtr = '0;
  logic [NPORTS-1:0] sup_force_rtr = '0, sup_clk_chg = '0, sd_clear = '0;
  logic tlp_valid = 1'b0, tlp_is_req = 1'b0, tlp_to_func = 1'b0, disp_ready = 1'b1;
  logic [PIDW-1:0] tlp_src = '0;
  logic [BUSW-1:0] tlp_dest_bus = '0;
  logic tlp_ready, disp_valid;
  logic [1:0] disp_code;
  logic [NPORTS-1:0] ifb_flush, replay_flush, hot_reset_req, credit_adv, sd_status;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  lnk_down_disposition #(.NPORTS(NPORTS), .BUSW(BUSW)) u_lnk_down_disposition (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .port_dn_role(port_dn_role),
    .port_bus(port_bus), .sup_part_dis(sup_part_dis), .sup_port_dis(sup_port_dis),
    .sup_mode_rtr(sup_mode_rtr), .sup_force_rtr(sup_force_rtr),
    .sup_clk_chg(sup_clk_chg), .sd_clear(sd_clear), .tlp_valid(tlp_valid),
    .tlp_ready(tlp_ready), .tlp_src(tlp_src), .tlp_is_req(tlp_is_req),
    .tlp_dest_bus(tlp_dest_bus), .tlp_to_func(tlp_to_func),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_code(disp_code),
    .ifb_flush(ifb_flush), .replay_flush(replay_flush),
    .hot_reset_req(hot_reset_req), .credit_adv(credit_adv), .sd_status(sd_status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Send one descriptor and check the disposition on the next clock.
  task automatic send(input string tag, input logic [PIDW-1:0] src, input logic req,
                      input logic [BUSW-1:0] bus, input logic func, input logic [1:0] exp);
    tlp_valid = 1'b1; tlp_src = src; tlp_is_req = req; tlp_dest_bus = bus; tlp_to_func = func;
    tick();
    tlp_valid = 1'b0;
    check({tag, " valid"}, 32'(disp_valid), 32'd1);
    check({tag, " code"}, 32'(disp_code), 32'(exp));
  endtask

  task automatic t_reset();
    check("R11 reset disp_valid", 32'(disp_valid), 0);
    check("R11 reset tlp_ready", 32'(tlp_ready), 1);
    check("R10 reset sd_status", 32'(sd_status), 0);
    check("R2 reset flush", 32'(ifb_flush | replay_flush), 0);
  endtask

  task automatic t_link_up();
    link_up = 4'b1111;
    tick();
    check("R7 credit pulse", 32'(credit_adv), 32'hF);
    tick();
    check("R7 credit one cycle", 32'(credit_adv), 0);
  endtask

  task automatic t_forward_live();
    send("R6 req to live bus", 2'd0, 1'b1, 8'h20, 1'b0, FWD);
    send("R6 unmatched bus", 2'd0, 1'b1, 8'h55, 1'b0, FWD);
  endtask

  task automatic t_down_dn();
    link_up[2] = 1'b0;
    tick();
    check("R2 ifb flush", 32'(ifb_flush), 32'h4);
    check("R2 replay flush", 32'(replay_flush), 32'h4);
    check("R1 no hot reset dn", 32'(hot_reset_req), 0);
    check("R8 sd set", 32'(sd_status), 32'h4);
    tick();
    check("R2 flush one cycle", 32'(ifb_flush | replay_flush), 0);
    send("R3 req to dead bus", 2'd0, 1'b1, 8'h20, 1'b0, UR);
    send("R4 cpl to dead bus", 2'd0, 1'b0, 8'h20, 1'b0, DROP);
    send("R5 own func dead", 2'd0, 1'b1, 8'h20, 1'b1, FWD);
    send("R6 cpl to live bus", 2'd0, 1'b0, 8'h30, 1'b0, FWD);
    send("R3 req from other dn", 2'd1, 1'b1, 8'h20, 1'b0, UR);
  endtask

  task automatic t_w1c();
    tick(); tick();
    check("R10 sticky", 32'(sd_status), 32'h4);
    sd_clear = 4'b0100;
    tick();
    sd_clear = '0;
    check("R10 w1c clears", 32'(sd_status), 0);
    link_up[2] = 1'b1;
    tick();
    check("R7 credit on re-up", 32'(credit_adv), 32'h4);
  endtask

  task automatic t_down_up();
    link_up[0] = 1'b0;
    tick();
    check("R1 hot reset", 32'(hot_reset_req), 32'h1);
    check("R2 flush up port", 32'(ifb_flush & replay_flush), 32'h1);
    check("R8 no sd on up port", 32'(sd_status), 0);
    tick();
    check("R1 hot reset one cycle", 32'(hot_reset_req), 0);
    link_up[0] = 1'b1;
    tick();
  endtask

  task automatic t_suppress();
    for (int k = 0; k < 6; k++) begin
      logic [NPORTS-1:0] m;
      m = 4'b1000;
      case (k)
        0: sup_part_dis  = m;
        1: sup_port_dis  = m;
        2: sup_mode_rtr  = m;
        3: sup_force_rtr = m;
        4: sup_clk_chg   = m;
        default: begin sup_port_dis = m; link_up[3] = 1'b0; end
      endcase
      tick();
      sup_part_dis = '0; sup_port_dis = '0; sup_mode_rtr = '0;
      sup_force_rtr = '0; sup_clk_chg = '0;
      if (k < 5) begin
        tick();
        link_up[3] = 1'b0;
        tick();
      end
      check("R9 qualifier suppresses", 32'(sd_status), 0);
      check("R2 flush when suppressed", 32'(ifb_flush), 32'h8);
      link_up[3] = 1'b1;
      tick();
    end
    tick();
    link_up[3] = 1'b0;
    tick();
    check("R9 qualifier cleared by link up", 32'(sd_status), 32'h8);
    sd_clear = 4'b1000;
    link_up[3] = 1'b1;
    tick();
    sd_clear = '0;
    tick();
  endtask

  task automatic t_handshake();
    disp_ready = 1'b0;
    send("R11 first held", 2'd0, 1'b0, 8'h30, 1'b0, FWD);
    check("R11 ready low", 32'(tlp_ready), 0);
    link_up[1] = 1'b0;
    tlp_valid = 1'b1; tlp_src = 2'd0; tlp_is_req = 1'b1; tlp_dest_bus = 8'h10; tlp_to_func = 1'b0;
    tick();
    check("R11 held valid", 32'(disp_valid), 1);
    check("R11 held code", 32'(disp_code), 32'(FWD));
    disp_ready = 1'b1;
    tick();
    tlp_valid = 1'b0;
    check("R11 second after release", 32'(disp_code), 32'(UR));
    tick();
    check("R11 drained", 32'(disp_valid), 0);
    link_up[1] = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_link_up();
    t_forward_live();
    t_down_dn();
    t_w1c();
    t_down_up();
    t_suppress();
    t_handshake();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule